// File: doc/BRIEF.md
# Host-to-Card Read Request Splitter

This block takes one transfer descriptor (starting byte address, byte length, and a selector for the largest allowed read size). It turns the descriptor into a series of memory read requests. Each request draws a tag from a small circular pool. Requests stop whenever every tag is in use.

Completion beats return on a tag-addressed port and may interleave freely across tags. A per-tag reorder store holds the beats until they can be released. The store sends them to a streaming output with ready/valid flow control, strictly in issue order. A tag returns to the pool only when the last beat of its data has been accepted on that output. After the final beat of the transfer is accepted, a one-cycle done pulse follows. A zero-length descriptor skips all requests and pulses done straight away.

Addresses and lengths count bytes. The three low bits of both are ignored (treated as zero), because the data path moves 8-byte beats.

Top module: `h2c_read_splitter`

## Requirements
- R1: Every request length is nonzero and no larger than the read size chosen when the descriptor was accepted. The selector `desc_rrs` decodes as 0 = 128 bytes, 1 = 256 bytes, and 2 or 3 = 512 bytes. Later changes to the selector have no effect on a transfer already running.
- R2: No request crosses a 4096-byte address boundary. The low 12 address bits plus the length never exceed 4096.
- R3: Requests are contiguous. The first starts at the descriptor address, and each later one starts where the previous one ended. Each request is as long as the smallest of three values: the bytes left, the read size, and the bytes up to the next 4096-byte boundary. The lengths add up to the descriptor length.
- R4: Tags are handed out in rotating order 0, 1, … TAG_N-1, 0, … starting from 0 after reset. At most TAG_N requests are outstanding.
- R5: A request stays outstanding until the last beat of its data has been accepted on the output. While TAG_N requests are outstanding, `req_valid` is low. If bytes remain, `req_valid` rises in the cycle right after the handshake that retires the oldest tag.
- R6: Completion beats may arrive interleaved across tags, in any order of tags. The output carries each request's beats in arrival order within the tag, and carries requests in issue order.
- R7: `out_last` is high exactly on the final beat of the transfer. `xfer_done` pulses for one cycle, in the cycle after that beat's handshake.
- R8: A descriptor whose length is below 8 bytes produces no request. `xfer_done` pulses in the cycle after the descriptor is accepted.
- R9: During reset, `req_valid`, `out_valid`, `xfer_done` and `desc_ready` are all low. Once reset is released, `desc_ready` is high. It goes low after a nonzero descriptor is accepted and stays low until the final beat is accepted.
- R10: While `req_valid` or `out_valid` is high and the matching ready is low, the payload holds steady and the valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and accepting a descriptor |
| desc_addr | input | ADDR_W | Transfer start byte address |
| desc_len | input | LEN_W | Transfer byte length |
| desc_rrs | input | 2 | Read size selector, sampled on acceptance |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | RLEN_W | Request byte length |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | Completion beat valid |
| cpl_tag | input | TAG_W | Tag of the completion beat |
| cpl_data | input | DATA_W | Completion beat data |
| cpl_last | input | 1 | Final beat for this tag |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | DATA_W | Output beat data |
| out_last | output | 1 | Final beat of the transfer |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The hardest state to reach is a full tag pool. In that state every outstanding request's data has already arrived, and the only thing stopping progress is the output side. Only then can the stall and the one-cycle resumption be seen apart from ordinary completion latency. The bench reaches this state by holding `out_ready` low for a long stretch during a transfer of many small pieces while the completion model keeps returning data. It then releases `out_ready`. Elsewhere the completion model picks a random outstanding tag for each beat, so beats of different tags interleave. A descriptor that starts 128 bytes below a 4096-byte boundary covers the boundary split.

// File: rtl/h2c_rs_pkg.sv
package h2c_rs_pkg;
  localparam int RRS_MAX = 512;
  localparam int RLEN_W  = $clog2(RRS_MAX) + 1;
  localparam int PAGE_B  = 4096;

  // Read size selector decode: 0 -> 128, 1 -> 256, otherwise 512 bytes
  function automatic logic [RLEN_W-1:0] rrs_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return RLEN_W'(128);
      2'd1:    return RLEN_W'(256);
      default: return RLEN_W'(512);
    endcase
  endfunction
endpackage

// File: rtl/h2c_rs_chunker.sv
module h2c_rs_chunker
  import h2c_rs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int BEAT_B = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [1:0]        ld_sel,
  input  logic              tag_ok,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RLEN_W-1:0] req_len,
  output logic              remain_zero,
  output logic              fire
);
  localparam int BND_W = $clog2(PAGE_B) + 1;

  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [RLEN_W-1:0] rrs_q, rrs_d;
  logic [BND_W-1:0]  to_bound;
  logic [LEN_W-1:0]  piece;
  logic              upd;

  // Bytes left before the next page boundary
  assign to_bound = BND_W'(PAGE_B) - {1'b0, cur_addr_q[BND_W-2:0]};

  always_comb begin
    piece = (remain_q < LEN_W'(rrs_q)) ? remain_q : LEN_W'(rrs_q);
    if (LEN_W'(to_bound) < piece) piece = LEN_W'(to_bound);
  end

  assign remain_zero = (remain_q == '0);
  assign req_valid   = !remain_zero && tag_ok;
  assign req_addr    = cur_addr_q;
  assign req_len     = RLEN_W'(piece);
  assign fire        = req_valid && req_ready;
  assign upd         = load || fire;

  always_comb begin
    cur_addr_d = cur_addr_q;
    remain_d   = remain_q;
    rrs_d      = rrs_q;
    if (load) begin
      cur_addr_d = ld_addr & ~ADDR_W'(BEAT_B - 1);
      remain_d   = ld_len & ~LEN_W'(BEAT_B - 1);
      rrs_d      = rrs_bytes(ld_sel);
    end else if (fire) begin
      cur_addr_d = cur_addr_q + ADDR_W'(piece);
      remain_d   = remain_q - piece;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_q <= '0;
      remain_q   <= '0;
      rrs_q      <= RLEN_W'(128);
    end else if (upd) begin
      cur_addr_q <= cur_addr_d;
      remain_q   <= remain_d;
      rrs_q      <= rrs_d;
    end
  end
endmodule

// File: rtl/h2c_rs_tagpool.sv
module h2c_rs_tagpool #(
  parameter int TAG_N = 4,
  parameter int TAG_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  output logic [TAG_W-1:0] tail_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic             avail,
  output logic             live,
  output logic             last_one
);
  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] t);
    return (t == TAG_W'(TAG_N - 1)) ? '0 : t + TAG_W'(1);
  endfunction

  assign tail_tag = tail_q;
  assign head_tag = head_q;
  assign avail    = (cnt_q != CNT_W'(TAG_N));
  assign live     = (cnt_q != '0);
  assign last_one = (cnt_q == CNT_W'(1));
  assign upd      = issue || retire;

  always_comb begin
    head_d = retire ? bump(head_q) : head_q;
    tail_d = issue  ? bump(tail_q) : tail_q;
    cnt_d  = cnt_q + CNT_W'(issue) - CNT_W'(retire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/h2c_rs_rob.sv
module h2c_rs_rob #(
  parameter int DATA_W = 64,
  parameter int TAG_N  = 4,
  parameter int TAG_W  = 2,
  parameter int BEATS  = 64,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_last,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic              head_live,
  input  logic              pop,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic              beat_end
);
  localparam int IDX_W = $clog2(TAG_N * BEATS);

  logic [DATA_W-1:0] mem [TAG_N*BEATS];
  logic [PTR_W-1:0]  wcnt [TAG_N];
  logic [TAG_N-1:0]  fin;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [PTR_W-1:0]  wsel, hcnt;
  logic [IDX_W-1:0]  widx, ridx;

  for (genvar t = 0; t < TAG_N; t++) begin : g_slot
    logic [PTR_W-1:0] cnt_q, cnt_d;
    logic             fin_q, fin_d, hit, clr;
    always_comb begin
      hit   = cpl_valid && (cpl_tag == TAG_W'(t));
      clr   = pop && beat_end && (head_tag == TAG_W'(t));
      cnt_d = cnt_q;
      fin_d = fin_q;
      if (clr) begin
        cnt_d = '0;
        fin_d = 1'b0;
      end else if (hit) begin
        cnt_d = cnt_q + PTR_W'(1);
        fin_d = cpl_last;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        fin_q <= 1'b0;
      end else if (hit || clr) begin
        cnt_q <= cnt_d;
        fin_q <= fin_d;
      end
    end
    assign wcnt[t] = cnt_q;
    assign fin[t]  = fin_q;
  end

  assign wsel = wcnt[cpl_tag];
  assign hcnt = wcnt[head_tag];
  assign widx = IDX_W'(cpl_tag) * IDX_W'(BEATS) + IDX_W'(wsel);
  assign ridx = IDX_W'(head_tag) * IDX_W'(BEATS) + IDX_W'(rptr_q);

  always_ff @(posedge clk) begin
    if (cpl_valid && (wsel < PTR_W'(BEATS))) mem[widx] <= cpl_data;
  end

  assign beat_valid = head_live && (rptr_q < hcnt);
  assign beat_data  = mem[ridx];
  assign beat_end   = fin[head_tag] && ((rptr_q + PTR_W'(1)) == hcnt);

  always_comb begin
    rptr_d = beat_end ? '0 : rptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr_q <= '0;
    else if (pop) rptr_q <= rptr_d;
  end
endmodule

// File: rtl/h2c_read_splitter.sv
module h2c_read_splitter
  import h2c_rs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int DATA_W = 64,
  parameter int TAG_N  = 4,
  parameter int TAG_W  = (TAG_N > 1) ? $clog2(TAG_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [1:0]        desc_rrs,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RLEN_W-1:0] req_len,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              xfer_done
);
  localparam int BEAT_B = DATA_W / 8;
  localparam int BEATS  = RRS_MAX / BEAT_B;
  localparam int PTR_W  = $clog2(BEATS) + 1;
  localparam int CNT_W  = $clog2(TAG_N + 1);

  logic [1:0]       rst_sync_q;
  logic             run;
  logic             busy_q, busy_d, done_q, done_d;
  logic             accept, len_nz, pop, retire, final_beat;
  logic             fire, remain_zero, avail, live, last_one, beat_end;
  logic [TAG_W-1:0] head_tag;

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  assign desc_ready = run && !busy_q;
  assign accept     = desc_valid && desc_ready;
  assign len_nz     = (desc_len & ~LEN_W'(BEAT_B - 1)) != '0;
  assign pop        = out_valid && out_ready;
  assign retire     = pop && beat_end;
  assign final_beat = retire && remain_zero && last_one;
  assign out_last   = beat_end && remain_zero && last_one;
  assign xfer_done  = done_q;

  h2c_rs_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_B(BEAT_B)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_addr(desc_addr), .ld_len(desc_len),
    .ld_sel(desc_rrs), .tag_ok(avail), .req_ready(req_ready), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .remain_zero(remain_zero), .fire(fire)
  );

  h2c_rs_tagpool #(.TAG_N(TAG_N), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .issue(fire), .retire(retire), .tail_tag(req_tag),
    .head_tag(head_tag), .avail(avail), .live(live), .last_one(last_one)
  );

  h2c_rs_rob #(.DATA_W(DATA_W), .TAG_N(TAG_N), .TAG_W(TAG_W), .BEATS(BEATS),
               .PTR_W(PTR_W)) u_rob (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_data(cpl_data), .cpl_last(cpl_last), .head_tag(head_tag), .head_live(live),
    .pop(pop), .beat_valid(out_valid), .beat_data(out_data), .beat_end(beat_end)
  );

  always_comb begin
    busy_d = busy_q;
    if (accept && len_nz) busy_d = 1'b1;
    else if (final_beat)  busy_d = 1'b0;
    done_d = (accept && !len_nz) || final_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/h2c_rs_checker.sv
module h2c_rs_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int DATA_W = 64,
  parameter int TAG_N  = 4,
  parameter int TAG_W  = 2,
  parameter int RLEN_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [LEN_W-1:0]  desc_len,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [RLEN_W-1:0] req_len,
  input logic [TAG_W-1:0]  req_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              xfer_done,
  input logic              retire
);
  localparam int IF_W = $clog2(TAG_N + 2) + 1;
  logic [IF_W-1:0] inflight;
  logic            small_len;

  assign small_len = (desc_len < LEN_W'(DATA_W / 8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + IF_W'(req_valid && req_ready) - IF_W'(retire);
  end

  p_len_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= RLEN_W'(512)));
  p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({2'b00, req_addr[11:0]} + 14'(req_len)) <= 14'd4096);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_tag));
  p_pool_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= IF_W'(TAG_N));
  p_stall_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == IF_W'(TAG_N)) |-> !req_valid);
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> xfer_done);
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && small_len |=> xfer_done && !req_valid);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && !small_len |=> !desc_ready);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

bind h2c_read_splitter h2c_rs_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .TAG_N(TAG_N), .TAG_W(TAG_W),
  .RLEN_W(h2c_rs_pkg::RLEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_len(desc_len), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .req_tag(req_tag), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .xfer_done(xfer_done), .retire(retire)
);

// File: tb/tb_h2c_read_splitter.sv
module tb_h2c_read_splitter;
  localparam int ADDR_W = 32, LEN_W = 20, DATA_W = 64, TAG_N = 4, TAG_W = 2, RLEN_W = 10;

  typedef struct { int addr; int len; int sel; } desc_t;
  typedef struct { int addr; int len; } req_t;
  typedef struct { int tag; int addr; int beats; int sent; } pend_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, desc_valid, desc_ready, req_valid, req_ready;
  logic [ADDR_W-1:0] desc_addr, req_addr;
  logic [LEN_W-1:0]  desc_len;
  logic [1:0]        desc_rrs;
  logic [RLEN_W-1:0] req_len;
  logic [TAG_W-1:0]  req_tag, cpl_tag;
  logic              cpl_valid, cpl_last, out_valid, out_ready, out_last, xfer_done;
  logic [DATA_W-1:0] cpl_data, out_data;

  h2c_read_splitter dut (.*);

  desc_t desc_q[$];
  req_t  exp_req[$];
  int    exp_beat[$];
  int    ret_q[$];
  pend_t pend[$];
  int    n_chk = 0, n_fail = 0, cyc = 0, mo = 0, next_tag = 0;
  bit    exp_done = 0, resume_chk = 0, busy_chk = 0, hold_out = 0, wd = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  function automatic logic [63:0] beat_of(input int a);
    return {32'(a), ~32'(a)};
  endfunction

  // Expected request list from the splitting rule (R1, R2, R3)
  function automatic void build(input int a, input int l, input int sel);
    int m, rem, ad, p, b;
    m   = (sel == 0) ? 128 : (sel == 1) ? 256 : 512;
    rem = l & ~7;
    ad  = a & ~7;
    while (rem > 0) begin
      p = (rem < m) ? rem : m;
      b = 4096 - (ad % 4096);
      if (b < p) p = b;
      exp_req.push_back('{ad, p});
      for (int k = 0; k < p / 8; k++) exp_beat.push_back(ad + 8 * k);
      ad += p;
      rem -= p;
    end
  endfunction

  // Stimulus and reference comparison, every cycle at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !wd) begin
        wd = 1;
        chk(0, "watchdog", cyc, 150000);
      end
      if (!rst_n) continue;
      req_ready = ($urandom % 4) != 0;
      out_ready = hold_out ? 1'b0 : (($urandom % 4) != 0);
      if (desc_q.size() != 0 && desc_ready) begin
        desc_valid = 1'b1;
        desc_addr  = desc_q[0].addr;
        desc_len   = LEN_W'(desc_q[0].len);
        desc_rrs   = 2'(desc_q[0].sel);
      end else begin
        desc_valid = 1'b0;
        desc_rrs   = 2'($urandom);
      end
      cpl_valid = 1'b0;
      if (pend.size() != 0 && ($urandom % 3) != 0) begin
        int i;
        i = $urandom % pend.size();
        cpl_valid = 1'b1;
        cpl_tag   = TAG_W'(pend[i].tag);
        cpl_data  = beat_of(pend[i].addr + 8 * pend[i].sent);
        cpl_last  = (pend[i].sent + 1 == pend[i].beats);
        pend[i].sent++;
        if (pend[i].sent == pend[i].beats) pend.delete(i);
      end
      #1;
      // R7 / R8: done pulse one cycle after its cause
      if (xfer_done || exp_done) chk(xfer_done == exp_done, "R7/R8 done", xfer_done, exp_done);
      exp_done = 0;
      if (busy_chk) chk(!desc_ready, "R9 busy", desc_ready, 0);
      busy_chk = 0;
      if (mo == TAG_N) chk(!req_valid, "R5 stall", req_valid, 0);
      if (resume_chk) chk(req_valid, "R5 resume", req_valid, 1);
      resume_chk = 0;
      if (req_valid && req_ready) begin
        if (exp_req.size() == 0) chk(0, "R3 extra request", req_addr, 0);
        else begin
          req_t e;
          e = exp_req.pop_front();
          chk(int'(req_addr) == e.addr, "R3 addr", req_addr, e.addr);
          chk(int'(req_len) == e.len, "R1/R2 len", req_len, e.len);
          chk(int'(req_tag) == next_tag, "R4 tag", req_tag, next_tag);
          pend.push_back('{int'(req_tag), e.addr, e.len / 8, 0});
          ret_q.push_back(e.len / 8);
        end
        next_tag = (next_tag + 1) % TAG_N;
        mo++;
      end
      if (out_valid && out_ready) begin
        if (exp_beat.size() == 0) chk(0, "R6 extra beat", out_data, 0);
        else begin
          int a;
          a = exp_beat.pop_front();
          chk(out_data == beat_of(a), "R6 data order", out_data, beat_of(a));
          chk(out_last == (exp_beat.size() == 0), "R7 last", out_last, exp_beat.size() == 0);
          if (exp_beat.size() == 0) exp_done = 1;
          ret_q[0]--;
          if (ret_q[0] == 0) begin
            void'(ret_q.pop_front());
            if (mo == TAG_N && exp_req.size() != 0) resume_chk = 1;
            mo--;
          end
        end
      end
      if (desc_valid && desc_ready) begin
        desc_t d;
        d = desc_q.pop_front();
        if ((d.len & ~7) == 0) exp_done = 1;
        else begin
          build(d.addr, d.len, d.sel);
          busy_chk = 1;
        end
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk);
    while (!wd && (desc_q.size() != 0 || exp_beat.size() != 0 || exp_req.size() != 0 ||
                   pend.size() != 0 || exp_done));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; desc_valid = 1'b0; desc_addr = '0; desc_len = '0; desc_rrs = '0;
    req_ready = 1'b0; cpl_valid = 1'b0; cpl_tag = '0; cpl_data = '0; cpl_last = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid, "R9 reset req_valid", req_valid, 0);
    chk(!out_valid, "R9 reset out_valid", out_valid, 0);
    chk(!xfer_done, "R9 reset xfer_done", xfer_done, 0);
    chk(!desc_ready, "R9 reset desc_ready", desc_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(desc_ready, "R9 idle desc_ready", desc_ready, 1);
    desc_q.push_back('{32'h1000, 32'h400, 0});  // 128-byte pieces, pool fills
    desc_q.push_back('{32'h1F80, 32'h300, 2});  // 4 KB boundary split
    desc_q.push_back('{32'h2000, 32'h4, 1});    // below one beat: zero length
    desc_q.push_back('{32'h0FF8, 32'h8, 1});    // single beat right under boundary
    desc_q.push_back('{32'h3E00, 32'h1000, 1}); // 256-byte pieces across a page
    desc_q.push_back('{32'h5000, 32'h208, 3});  // 512 plus leftover 8
    wait_idle();
    hold_out = 1;                               // full pool held by the output side
    desc_q.push_back('{32'h8000, 32'h800, 0});
    repeat (200) @(negedge clk);
    hold_out = 0;
    wait_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule